// File: doc/BRIEF.md
# Port-Latched 16K Bank Mapper

This block maps a 16-bit processor address onto a 512 KiB DRAM space. That space is split into 32 physical banks of 16 KiB. A 5-bit configuration register holds the memory map. An I/O write with the right address and data pattern loads it. For every processor access, the top two address bits choose one of four 16 KiB slots. The configuration then picks the physical bank for that slot. Configurations 0 to 7 give the classic eight maps of a 128 KiB machine. Configurations 8 to 31 put the expansion bank with the same number in the second slot. In those maps the other slots hold banks 0, 2 and 7.

Display fetches use the same address input, marked by a separate flag, and are never moved by the banking. The bank for a display fetch comes straight from its top two address bits. The outputs are the physical bank, two CAS group enables (one for the lower 256 KiB and one for the upper 256 KiB), the 14-bit in-bank offset and the full 19-bit byte address.

A build parameter selects a reduced 320 KiB variant. In that variant only banks 0 to 19 exist. Configurations above 19 raise an invalid-bank flag and send the second slot to bank 1.

Top module: `bank_mapper`

## Requirements
- R1: After reset the configuration is 0. The slots at 0000h, 4000h, 8000h and C000h map to banks 0, 1, 2 and 3.
- R2: The configuration loads on the clock edge where ioWrEn is 1, ioAddrTop is 0 and ioData[7:6] is 2'b11. In that case ioData[4:0] is stored and ioData[5] is ignored. Any other write leaves the configuration unchanged.
- R3: For configurations 0 to 7, the banks for slots 0,1,2,3 are: cfg0 = 0,1,2,3; cfg1 = 0,1,2,7; cfg2 = 4,5,6,7; cfg3 = 0,3,2,7; cfg4 to cfg7 = 0,cfg,2,3.
- R4: For configurations 8 to 31 in the full build, slot 1 maps to the bank equal to the configuration. Slots 0, 2 and 3 map to banks 0, 2 and 7.
- R5: Exactly one of casLow and casHigh is 1. casHigh is 1 only for a processor access to slot 1 whose bank has bit 4 set.
- R6: When accVideo is 1, physBank equals {3'b000, memAddr[15:14]} for every configuration, and casLow is 1.
- R7: memOffset equals memAddr[13:0]. physAddr equals physBank*16384 + memOffset.
- R8: With REDUCED_BUILD=1, a configuration above 19 sets bankInvalid and maps slot 1 to bank 1. With REDUCED_BUILD=0, bankInvalid stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | I/O write strobe, sampled on the rising edge |
| ioAddrTop | input | 1 | Bit 15 of the I/O write address |
| ioData | input | 8 | I/O write data |
| accVideo | input | 1 | 1 = display fetch, 0 = processor access |
| memAddr | input | 16 | Access address |
| physBank | output | 5 | Physical bank number |
| casLow | output | 1 | CAS enable, banks 0 to 15 |
| casHigh | output | 1 | CAS enable, banks 16 to 31 |
| memOffset | output | 14 | Offset within the bank |
| physAddr | output | 19 | Physical byte address |
| bankInvalid | output | 1 | Configuration selects a missing bank (reduced build) |

## Verification
The clocked properties assume that the mapping inputs (accVideo, memAddr) are stable in the sampling window around each rising edge. They also assume that ioWrEn and ioData change only away from that edge. The bench drives every input on the falling edge and samples the combinational outputs a quarter period later. A configuration write therefore lands at exactly one rising edge. The full and reduced builds run side by side on shared inputs, so every configuration is checked against both maps.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int CFG_W   = 5;
  localparam int SLOT_W  = 2;
  localparam int OFFS_W  = 14;
  localparam int ADDR_W  = SLOT_W + OFFS_W;
  localparam int PHYS_W  = CFG_W + OFFS_W;
  localparam int NUM_SLOTS = 1 << SLOT_W;

  // control-to-datapath strobes
  typedef struct packed {
    logic [CFG_W-1:0] cfg;
    logic             expMode;
    logic             badBank;
  } mapCtrl_t;
endpackage

// File: rtl/bank_mapper_ctrl.sv
module bank_mapper_ctrl
  import bank_mapper_pkg::*;
#(
  parameter bit REDUCED_BUILD    = 1'b0,
  parameter int LAST_REDUCED_CFG = 19,
  parameter int FIRST_EXP_CFG    = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioWrEn,
  input  logic       ioAddrTop,
  input  logic [7:0] ioData,
  output mapCtrl_t   ctrl
);
  logic [CFG_W-1:0] cfgQ;
  logic             loadHit;
  logic             unusedDataBit;

  assign unusedDataBit = ioData[5];
  assign loadHit = ioWrEn && !ioAddrTop && (ioData[7:6] == 2'b11);

  always_ff @(posedge clk) begin
    if (!rstN)        cfgQ <= '0;
    else if (loadHit) cfgQ <= ioData[CFG_W-1:0];
  end

  assign ctrl.cfg     = cfgQ;
  assign ctrl.expMode = (32'(cfgQ) >= FIRST_EXP_CFG);
  assign ctrl.badBank = REDUCED_BUILD && (32'(cfgQ) > LAST_REDUCED_CFG);

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && !ioAddrTop && ioData[7:6] == 2'b11) |=> (cfgQ == $past(ioData[4:0])));

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ioWrEn && !ioAddrTop && ioData[7:6] == 2'b11) |=> $stable(cfgQ));
endmodule

// File: rtl/bank_mapper_dp.sv
module bank_mapper_dp
  import bank_mapper_pkg::*;
#(
  parameter bit REDUCED_BUILD    = 1'b0,
  parameter int LAST_REDUCED_CFG = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapCtrl_t          ctrl,
  input  logic              accVideo,
  input  logic [ADDR_W-1:0] memAddr,
  output logic [CFG_W-1:0]  physBank,
  output logic              casLow,
  output logic              casHigh,
  output logic [OFFS_W-1:0] memOffset,
  output logic [PHYS_W-1:0] physAddr
);
  localparam int HOME_BANK_S3 = 3;
  localparam int ALT_BANK_S3  = 7;

  logic [CFG_W-1:0]  slotBank [NUM_SLOTS];
  logic [SLOT_W-1:0] slotSel;

  function automatic logic [CFG_W-1:0] pickBank(input int slot, input mapCtrl_t c);
    logic [CFG_W-1:0] b;
    b = CFG_W'(slot);
    if (c.expMode) begin
      case (slot)
        1:       b = c.badBank ? CFG_W'(1) : c.cfg;
        3:       b = CFG_W'(ALT_BANK_S3);
        default: b = CFG_W'(slot);
      endcase
    end else begin
      case (c.cfg[2:0])
        3'd0: b = CFG_W'(slot);
        3'd1: b = (slot == 3) ? CFG_W'(ALT_BANK_S3) : CFG_W'(slot);
        3'd2: b = CFG_W'(slot + 4);
        3'd3: b = (slot == 3) ? CFG_W'(ALT_BANK_S3) :
                  (slot == 1) ? CFG_W'(3) : CFG_W'(slot);
        default: b = (slot == 1) ? c.cfg :
                     (slot == 3) ? CFG_W'(HOME_BANK_S3) : CFG_W'(slot);
      endcase
    end
    return b;
  endfunction

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : slotGen
    always_comb slotBank[s] = pickBank(s, ctrl);
  end

  assign slotSel   = memAddr[ADDR_W-1:OFFS_W];
  assign memOffset = memAddr[OFFS_W-1:0];

  always_comb begin
    if (accVideo) physBank = {{(CFG_W-SLOT_W){1'b0}}, slotSel};
    else          physBank = slotBank[slotSel];
  end

  assign casHigh  = physBank[CFG_W-1];
  assign casLow   = !casHigh;
  assign physAddr = {physBank, memOffset};

  // R5
  cas_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({casHigh, casLow}));

  // R5
  cas_high_scope_chk: assert property (@(posedge clk) disable iff (!rstN)
    casHigh |-> (!accVideo && memAddr[15:14] == 2'b01));

  // R6
  video_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    accVideo |-> (physBank == {3'b000, memAddr[15:14]}));

  // R7
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[13:0] == memAddr[13:0]);

  // R8
  reduced_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (REDUCED_BUILD && !accVideo) |-> (32'(physBank) <= LAST_REDUCED_CFG));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter bit REDUCED_BUILD    = 1'b0,
  parameter int LAST_REDUCED_CFG = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic              ioAddrTop,
  input  logic [7:0]        ioData,
  input  logic              accVideo,
  input  logic [ADDR_W-1:0] memAddr,
  output logic [CFG_W-1:0]  physBank,
  output logic              casLow,
  output logic              casHigh,
  output logic [OFFS_W-1:0] memOffset,
  output logic [PHYS_W-1:0] physAddr,
  output logic              bankInvalid
);
  mapCtrl_t ctrl;

  bank_mapper_ctrl #(
    .REDUCED_BUILD(REDUCED_BUILD),
    .LAST_REDUCED_CFG(LAST_REDUCED_CFG)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddrTop(ioAddrTop),
    .ioData(ioData), .ctrl(ctrl)
  );

  bank_mapper_dp #(
    .REDUCED_BUILD(REDUCED_BUILD),
    .LAST_REDUCED_CFG(LAST_REDUCED_CFG)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .accVideo(accVideo),
    .memAddr(memAddr), .physBank(physBank), .casLow(casLow),
    .casHigh(casHigh), .memOffset(memOffset), .physAddr(physAddr)
  );

  assign bankInvalid = ctrl.badBank;
endmodule

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb_top;
  localparam int CLK_PERIOD = 10;
  // banks for slots 3,2,1,0 packed per configuration 0..7 (R3)
  localparam logic [19:0] BASE_MAP [8] = '{
    {5'd3, 5'd2, 5'd1, 5'd0}, {5'd7, 5'd2, 5'd1, 5'd0},
    {5'd7, 5'd6, 5'd5, 5'd4}, {5'd7, 5'd2, 5'd3, 5'd0},
    {5'd3, 5'd2, 5'd4, 5'd0}, {5'd3, 5'd2, 5'd5, 5'd0},
    {5'd3, 5'd2, 5'd6, 5'd0}, {5'd3, 5'd2, 5'd7, 5'd0}};

  logic clk = 0, rstN = 0, ioWrEn = 0, ioAddrTop = 0, accVideo = 0;
  logic [7:0] ioData = 0;
  logic [15:0] memAddr = 0;
  logic [4:0] physBank, physBankR;
  logic casLow, casHigh, casLowR, casHighR, bankInvalid, bankInvalidR;
  logic [13:0] memOffset, memOffsetR;
  logic [18:0] physAddr, physAddrR;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_mapper #(.REDUCED_BUILD(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddrTop(ioAddrTop), .ioData(ioData),
    .accVideo(accVideo), .memAddr(memAddr), .physBank(physBank), .casLow(casLow),
    .casHigh(casHigh), .memOffset(memOffset), .physAddr(physAddr), .bankInvalid(bankInvalid));

  bank_mapper #(.REDUCED_BUILD(1'b1)) dutRed_i (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddrTop(ioAddrTop), .ioData(ioData),
    .accVideo(accVideo), .memAddr(memAddr), .physBank(physBankR), .casLow(casLowR),
    .casHigh(casHighR), .memOffset(memOffsetR), .physAddr(physAddrR), .bankInvalid(bankInvalidR));

  function automatic int expBank(int cfg, int slot, bit video, bit reduced);
    if (video) return slot;
    if (cfg < 8) return int'(BASE_MAP[cfg][slot*5 +: 5]);
    if (slot == 1) return (reduced && cfg > 19) ? 1 : cfg;
    return (slot == 0) ? 0 : (slot == 2) ? 2 : 7;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ioWrite(logic top, logic [7:0] d, logic en = 1'b1);
    @(negedge clk);
    ioWrEn = en; ioAddrTop = top; ioData = d;
    @(negedge clk);
    ioWrEn = 0; ioAddrTop = 0; ioData = 0;
  endtask

  task automatic look(int slot, bit video, logic [13:0] offs);
    accVideo = video;
    memAddr = {slot[1:0], offs};
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset map
    for (int s = 0; s < 4; s++) begin
      look(s, 0, 14'h0);
      chk(physBank == 5'(s), "R1", "reset bank", physBank, s);
    end
    chk(bankInvalidR == 0, "R1", "reset invalid", bankInvalidR, 0);

    // main sweep R3 R4 R5 R6 R7 R8
    for (int cfg = 0; cfg < 32; cfg++) begin
      ioWrite(1'b0, 8'hC0 | 8'(cfg));
      for (int s = 0; s < 4; s++) begin
        for (int v = 0; v < 2; v++) begin
          logic [13:0] offs;
          int eb, ebR;
          offs = 14'(16'h1A5 * (cfg + 1) + s * 977 + v);
          look(s, v[0], offs);
          eb  = expBank(cfg, s, v[0], 1'b0);
          ebR = expBank(cfg, s, v[0], 1'b1);
          chk(physBank == 5'(eb), (v != 0) ? "R6" : (cfg < 8) ? "R3" : "R4",
              "bank", physBank, eb);
          chk(casHigh == (eb >= 16) && casLow == (eb < 16), "R5", "cas group",
              {casHigh, casLow}, (eb >= 16) ? 2 : 1);
          chk(memOffset == offs && physAddr == 19'(eb * 16384 + int'(offs)), "R7",
              "phys addr", physAddr, eb * 16384 + int'(offs));
          chk(physBankR == 5'(ebR), "R8", "reduced bank", physBankR, ebR);
        end
      end
      chk(bankInvalid == 0, "R8", "full invalid", bankInvalid, 0);
      chk(bankInvalidR == (cfg > 19), "R8", "reduced invalid", bankInvalidR, cfg > 19);
    end

    // R2 ignored writes
    ioWrite(1'b0, 8'hC5);
    ioWrite(1'b1, 8'hD6);
    look(1, 0, 14'h0);
    chk(physBank == 5'd5, "R2", "addr bit15 high ignored", physBank, 5);
    ioWrite(1'b0, 8'h86);
    look(1, 0, 14'h0);
    chk(physBank == 5'd5, "R2", "data 7:6 not 11 ignored", physBank, 5);
    ioWrite(1'b0, 8'h46);
    look(1, 0, 14'h0);
    chk(physBank == 5'd5, "R2", "data 7:6=01 ignored", physBank, 5);
    ioWrite(1'b0, 8'hD6, 1'b0);
    look(1, 0, 14'h0);
    chk(physBank == 5'd5, "R2", "no strobe ignored", physBank, 5);
    ioWrite(1'b0, 8'hE9);
    look(1, 0, 14'h0);
    chk(physBank == 5'd9, "R2", "bit5 dropped", physBank, 9);
    look(3, 0, 14'h0);
    chk(physBank == 5'd7, "R2", "bit5 dropped slot3", physBank, 7);

    // R1 reset mid-run
    ioWrite(1'b0, 8'hDF);
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    for (int s = 0; s < 4; s++) begin
      look(s, 0, 14'h3FFF);
      chk(physBank == 5'(s) && physAddr == 19'(s * 16384 + 16383), "R1",
          "re-reset map", physAddr, s * 16384 + 16383);
    end
    chk(bankInvalidR == 0, "R1", "re-reset invalid", bankInvalidR, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule